// File: doc/BRIEF.md
# Mirrored Video Controller Register Bank

This block is the CPU-facing register file of a sprite and character video controller. A synchronous CPU bus (chip select, write enable, 10-bit address, byte-wide write and read data) reaches 47 byte registers. The block decodes only the low six address bits, so the 47-register window repeats sixteen times across the 1 KB address space. The unused tail of each 64-byte window reads as all ones.

Readback follows fixed rules. Bits with no storage read as one. Colour registers keep only a nibble. Two register locations return the live raster line count instead of stored data. The two collision registers collect per-sprite collision pulses from the display logic and clear when the CPU reads them. The interrupt flag and mask locations are not stored here. Their read values come in on side inputs, and a write to either raises a strobe so that the interrupt logic can take the write data from the bus. All stored contents go out on one flat vector for the pixel and fetch logic.

Top module: `vreg_bank`

## Requirements
- R1: Address bits 9:6 are ignored. A register at offset k (the low six bits) is read and written identically through any of the sixteen 64-byte windows.
- R2: Offsets 0x2F to 0x3F hold no register. A read of them returns 0xFF, and a write to them changes no stored byte and no output.
- R3: Offsets 0x20 to 0x2E store only bits 3:0 of a write, and a read returns 0xF in bits 7:4.
- R4: Bits without storage read as 1 whatever was written: bits 7:6 at 0x16, bit 0 at 0x18, bits 6:4 at 0x19, and bits 7:4 at 0x1A.
- R5: After reset, a read returns 0x1B at 0x11 (bit 7 shows raster bit 8), 0xC8 at 0x16 and 0x15 at 0x18. Every other stored bit is 0, and `rdata` is 0x00.
- R6: A read (cs=1, we=0) puts its value on `rdata` at the next rising clock edge. `rdata` then holds that value until the next read.
- R7: A read of 0x12 returns `raster_i[7:0]`, and bit 7 of a read of 0x11 returns `raster_i[8]`, both as sampled in the read cycle. Written values at these locations are kept and exported on `regs_o`.
- R8: Each clock, bits of `coll_ss_i` are ORed into offset 0x1E and bits of `coll_sb_i` into offset 0x1F. The CPU cannot write these two registers.
- R9: A read of 0x1E or 0x1F returns the register's value from before the read and clears that register at the same edge. A pulse arriving in the read cycle stays set afterwards.
- R10: A read of 0x19 returns `irq_flag_i | 0x70`, and a read of 0x1A returns `irq_mask_i | 0xF0`. A write to either raises `flag_wr_o` or `mask_wr_o` in that same cycle and stores nothing.
- R11: `regs_o[8k+7:8k]` carries the stored byte of offset k. Bits without storage are 0 there, and offsets 0x19 and 0x1A are 0. Ordinary registers such as 0x00 to 0x10 store all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Bus access in this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte address; only bits 5:0 select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| raster_i | input | 9 | Live raster line count |
| coll_ss_i | input | 8 | Sprite-to-sprite collision pulses, one per sprite |
| coll_sb_i | input | 8 | Sprite-to-background collision pulses, one per sprite |
| irq_flag_i | input | 8 | Interrupt flag value for reads of 0x19 |
| irq_mask_i | input | 8 | Interrupt mask value for reads of 0x1A |
| flag_wr_o | output | 1 | Write strobe for the interrupt flag location |
| mask_wr_o | output | 1 | Write strobe for the interrupt mask location |
| regs_o | output | 376 | Stored contents of all 47 offsets, byte k at bits 8k+7:8k |

## Verification
The hardest case to reach is a collision pulse that lands in the same cycle as the CPU read that clears that register. The read must return the old contents, and the new bit must still be set afterwards. Random stimulus rarely lines these up on the right register. A directed step therefore sets a bit, then drives a different bit on the same edge as the clearing read, and reads again. Random traffic then drives sparse pulses on both collision inputs while it reads the collision offsets through randomly chosen mirror windows. A bench model tracks the accumulate-and-clear behaviour cycle by cycle.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
    localparam int NREG  = 47;
    localparam int SEL_W = 6;
    localparam int NSPR  = 8;

    localparam logic [SEL_W-1:0] OFF_CR1   = 6'h11;
    localparam logic [SEL_W-1:0] OFF_RAST  = 6'h12;
    localparam logic [SEL_W-1:0] OFF_CR2   = 6'h16;
    localparam logic [SEL_W-1:0] OFF_MPTR  = 6'h18;
    localparam logic [SEL_W-1:0] OFF_IFLAG = 6'h19;
    localparam logic [SEL_W-1:0] OFF_IMASK = 6'h1A;
    localparam logic [SEL_W-1:0] OFF_CSS   = 6'h1E;
    localparam logic [SEL_W-1:0] OFF_CSB   = 6'h1F;
    localparam logic [SEL_W-1:0] OFF_COL0  = 6'h20;

    typedef logic [NREG-1:0][7:0] regfile_t;

    // Bits with no storage behind them; they read back as ones.
    function automatic logic [7:0] hi_mask(input logic [SEL_W-1:0] off);
        logic [7:0] m;
        m = 8'h00;
        if (off >= OFF_COL0 && int'(off) < NREG) m = 8'hF0;
        case (off)
            OFF_CR2:   m = 8'hC0;
            OFF_MPTR:  m = 8'h01;
            OFF_IFLAG: m = 8'h70;
            OFF_IMASK: m = 8'hF0;
            default:   ;
        endcase
        return m;
    endfunction

    // Stored reset pattern (masked bits held at zero).
    function automatic logic [7:0] rst_val(input logic [SEL_W-1:0] off);
        case (off)
            OFF_CR1:  return 8'h1B;
            OFF_CR2:  return 8'h08;
            OFF_MPTR: return 8'h14;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic cpu_writable(input logic [SEL_W-1:0] off);
        return (int'(off) < NREG) && (off != OFF_IFLAG) && (off != OFF_IMASK)
            && (off != OFF_CSS) && (off != OFF_CSB);
    endfunction
endpackage

// File: rtl/vreg_decode.sv
module vreg_decode
    import vreg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [SEL_W-1:0]  off,
    output logic              rd_en,
    output logic              wr_en,
    output logic              flag_wr,
    output logic              mask_wr
);
    // Upper bits only choose the mirror window and carry no meaning.
    logic unused_win;
    assign unused_win = ^addr[ADDR_W-1:SEL_W];

    always_comb begin
        off     = addr[SEL_W-1:0];
        rd_en   = cs & ~we;
        wr_en   = cs & we;
        flag_wr = wr_en && (off == OFF_IFLAG);
        mask_wr = wr_en && (off == OFF_IMASK);
    end
endmodule

// File: rtl/vreg_store.sv
module vreg_store
    import vreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] off,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic [NSPR-1:0]  coll_ss,
    input  logic [NSPR-1:0]  coll_sb,
    output regfile_t         regs
);
    typedef struct packed {
        regfile_t regs;
    } store_t;

    store_t st_d, st_q;

    function automatic store_t init_state();
        store_t s;
        for (int i = 0; i < NREG; i++) s.regs[i] = rst_val(SEL_W'(i));
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && off == SEL_W'(i) && cpu_writable(SEL_W'(i)))
                st_d.regs[i] = wdata & ~hi_mask(SEL_W'(i));
        end
        st_d.regs[OFF_CSS] = ((rd_en && off == OFF_CSS) ? 8'h00 : st_q.regs[OFF_CSS]) | coll_ss;
        st_d.regs[OFF_CSB] = ((rd_en && off == OFF_CSB) ? 8'h00 : st_q.regs[OFF_CSB]) | coll_sb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= init_state();
        else        st_q <= st_d;
    end

    assign regs = st_q.regs;

    // R9
    coll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && off == OFF_CSS && coll_ss == '0) |=> (st_q.regs[OFF_CSS] == 8'h00));

    // R8
    coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && off == OFF_CSB) |=>
            ((st_q.regs[OFF_CSB] & $past(st_q.regs[OFF_CSB])) == $past(st_q.regs[OFF_CSB])));

    // R9
    coll_keep_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && off == OFF_CSS) |=> ((st_q.regs[OFF_CSS] & $past(coll_ss)) == $past(coll_ss)));
endmodule

// File: rtl/vreg_rdmux.sv
module vreg_rdmux
    import vreg_pkg::*;
#(
    parameter int RAST_W = 9
) (
    input  logic [SEL_W-1:0]  off,
    input  regfile_t          regs,
    input  logic [RAST_W-1:0] raster,
    input  logic [7:0]        irq_flag,
    input  logic [7:0]        irq_mask,
    output logic [7:0]        value
);
    always_comb begin
        value = 8'hFF;
        if (int'(off) < NREG) begin
            case (off)
                OFF_CR1:   value = {raster[8], regs[OFF_CR1][6:0]};
                OFF_RAST:  value = raster[7:0];
                OFF_IFLAG: value = irq_flag | hi_mask(off);
                OFF_IMASK: value = irq_mask | hi_mask(off);
                default:   value = regs[off] | hi_mask(off);
            endcase
        end
    end
endmodule

// File: rtl/vreg_bank.sv
module vreg_bank
    import vreg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RAST_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic [RAST_W-1:0]   raster_i,
    input  logic [NSPR-1:0]     coll_ss_i,
    input  logic [NSPR-1:0]     coll_sb_i,
    input  logic [7:0]          irq_flag_i,
    input  logic [7:0]          irq_mask_i,
    output logic                flag_wr_o,
    output logic                mask_wr_o,
    output logic [NREG*8-1:0]   regs_o
);
    typedef struct packed {
        logic [7:0] rdata;
    } bus_t;

    logic [SEL_W-1:0] off;
    logic             rd_en, wr_en;
    logic [7:0]       rd_value;
    regfile_t         regs;
    bus_t             bus_d, bus_q;

    vreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cs(cs), .we(we), .addr(addr), .off(off),
        .rd_en(rd_en), .wr_en(wr_en), .flag_wr(flag_wr_o), .mask_wr(mask_wr_o)
    );

    vreg_store u_store (
        .clk(clk), .rst_n(rst_n), .off(off), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .coll_ss(coll_ss_i), .coll_sb(coll_sb_i), .regs(regs)
    );

    vreg_rdmux #(.RAST_W(RAST_W)) u_rdmux (
        .off(off), .regs(regs), .raster(raster_i),
        .irq_flag(irq_flag_i), .irq_mask(irq_mask_i), .value(rd_value)
    );

    always_comb begin
        bus_d = bus_q;
        if (rd_en) bus_d.rdata = rd_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign rdata  = bus_q.rdata;
    assign regs_o = regs;

    // R2
    gap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr[SEL_W-1:0]) >= NREG) |=> (rdata == 8'hFF));

    // R7
    raster_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && addr[SEL_W-1:0] == OFF_RAST) |=> (rdata == $past(raster_i[7:0])));

    // R4
    unconn_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && addr[SEL_W-1:0] == OFF_CR2) |=> (rdata[7:6] == 2'b11));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !we) |=> $stable(rdata));
endmodule

// File: tb/vreg_bank_tb.sv
module vreg_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 47;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0;
    logic [9:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [8:0]  raster = '0;
    logic [7:0]  css = '0, csb = '0, iflag = '0, imask = '0;
    logic        flag_wr, mask_wr;
    logic [NR*8-1:0] regs_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m [0:63];
    logic [7:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .raster_i(raster), .coll_ss_i(css), .coll_sb_i(csb),
        .irq_flag_i(iflag), .irq_mask_i(imask), .flag_wr_o(flag_wr),
        .mask_wr_o(mask_wr), .regs_o(regs_o)
    );

    function automatic logic [7:0] bmask(input int o);
        if (o == 'h16) return 8'hC0;
        if (o == 'h18) return 8'h01;
        if (o == 'h19) return 8'h70;
        if (o == 'h1A) return 8'hF0;
        if (o >= 'h20 && o <= 'h2E) return 8'hF0;
        return 8'h00;
    endfunction

    function automatic logic bwritable(input int o);
        return o < NR && o != 'h19 && o != 'h1A && o != 'h1E && o != 'h1F;
    endfunction

    function automatic logic [7:0] bread(input int o);
        if (o >= NR) return 8'hFF;
        if (o == 'h11) return {raster[8], m[o][6:0]};
        if (o == 'h12) return raster[7:0];
        if (o == 'h19) return iflag | 8'h70;
        if (o == 'h1A) return imask | 8'hF0;
        return m[o] | bmask(o);
    endfunction

    function automatic logic [NR*8-1:0] bflat();
        logic [NR*8-1:0] v;
        for (int i = 0; i < NR; i++)
            v[i*8 +: 8] = (i == 'h19 || i == 'h1A) ? 8'h00 : m[i];
        return v;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_flat(input string req);
        logic [NR*8-1:0] e;
        e = bflat();
        checks++;
        if (regs_o !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, regs_o, e);
        end
    endtask

    // One bus cycle; entered and left at a falling edge.
    task automatic op(input logic c, input logic w, input logic [9:0] a,
                      input logic [7:0] d, input logic [7:0] ss, input logic [7:0] sb,
                      input string req);
        int o;
        logic rd;
        logic [7:0] exp;
        o = int'(a[5:0]);
        cs = c; we = w; addr = a; wdata = d; css = ss; csb = sb;
        #1;
        rd = c && !w;
        exp = bread(o);
        // R10 strobes in the write cycle
        check8({req, " R10 strobes"}, {6'd0, flag_wr, mask_wr},
               {6'd0, c && w && o == 'h19, c && w && o == 'h1A});
        @(posedge clk);
        if (c && w && bwritable(o)) m[o] = d & ~bmask(o);
        m['h1E] = ((rd && o == 'h1E) ? 8'h00 : m['h1E]) | ss;
        m['h1F] = ((rd && o == 'h1F) ? 8'h00 : m['h1F]) | sb;
        if (rd) last_rd = exp;
        @(negedge clk);
        cs = 0; we = 0; css = '0; csb = '0;
        check8({req, " R6 rdata"}, rdata, last_rd);
        check_flat({req, " R11 regs_o"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) m[i] = 8'h00;
        m['h11] = 8'h1B; m['h16] = 8'h08; m['h18] = 8'h14;
        last_rd = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        check8("R5 rdata after reset", rdata, 8'h00);
        check_flat("R5 regs_o after reset");
        op(1, 0, 10'h011, 0, 0, 0, "R5 0x11");
        check8("R5 0x11", rdata, 8'h1B);
        op(1, 0, 10'h016, 0, 0, 0, "R5 0x16");
        check8("R5 0x16", rdata, 8'hC8);
        op(1, 0, 10'h018, 0, 0, 0, "R5 0x18");
        check8("R5 0x18", rdata, 8'h15);

        // R1 mirror: write through window 15, read through window 0
        op(1, 1, 10'h3C5, 8'hA5, 0, 0, "R1 write");
        op(1, 0, 10'h005, 0, 0, 0, "R1 read");
        check8("R1 mirror", rdata, 8'hA5);
        // R11 plain register 0x10 keeps all bits
        op(1, 1, 10'h150, 8'hFF, 0, 0, "R11 write");
        check8("R11 0x10 export", regs_o[8'h10*8 +: 8], 8'hFF);

        // R2 gap write ignored, gap reads 0xFF
        op(1, 1, 10'h030, 8'h00, 0, 0, "R2 gap write");
        op(1, 0, 10'h22F, 0, 0, 0, "R2 gap read");
        check8("R2 gap", rdata, 8'hFF);

        // R3 colour nibble
        op(1, 1, 10'h020, 8'h5A, 0, 0, "R3 write");
        check8("R3 stored", regs_o[8'h20*8 +: 8], 8'h0A);
        op(1, 0, 10'h060, 0, 0, 0, "R3 read");
        check8("R3 read", rdata, 8'hFA);

        // R4 unconnected bits
        op(1, 1, 10'h018, 8'h00, 0, 0, "R4 write");
        op(1, 0, 10'h018, 0, 0, 0, "R4 read");
        check8("R4 0x18 bit0", rdata, 8'h01);

        // R7 raster readback
        raster = 9'h1AB;
        op(1, 1, 10'h012, 8'h33, 0, 0, "R7 write");
        check8("R7 stored compare", regs_o[8'h12*8 +: 8], 8'h33);
        op(1, 0, 10'h012, 0, 0, 0, "R7 read low");
        check8("R7 low", rdata, 8'hAB);
        op(1, 0, 10'h051, 0, 0, 0, "R7 read high");
        check8("R7 bit8", rdata[7:0] & 8'h80, 8'h80);

        // R8 accumulate, write ignored; R9 clear with coincident pulse
        op(0, 0, 10'h000, 0, 8'h01, 8'h00, "R8 pulse");
        op(1, 1, 10'h01E, 8'hFF, 8'h00, 8'h00, "R8 write ignored");
        check8("R8 write ignored", regs_o[8'h1E*8 +: 8], 8'h01);
        op(1, 0, 10'h09E, 0, 8'h80, 8'h00, "R9 read clr");
        check8("R9 old value", rdata, 8'h01);
        op(1, 0, 10'h01E, 0, 8'h00, 8'h00, "R9 reread");
        check8("R9 new bit kept", rdata, 8'h80);

        // R10 delegated locations
        iflag = 8'h05; imask = 8'h03;
        op(1, 0, 10'h019, 0, 0, 0, "R10 flag read");
        check8("R10 flag", rdata, 8'h75);
        op(1, 0, 10'h01A, 0, 0, 0, "R10 mask read");
        check8("R10 mask", rdata, 8'hF3);
        op(1, 1, 10'h019, 8'h0F, 0, 0, "R10 flag write");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [9:0] a;
            logic [7:0] ss, sb;
            raster = 9'($urandom);
            iflag = 8'($urandom);
            imask = 8'($urandom);
            a = 10'($urandom);
            if ($urandom % 3 == 0) a[5:0] = ($urandom % 2) ? 6'h1E : 6'h1F;
            ss = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            sb = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            op(($urandom % 5) != 0, ($urandom % 2) == 0, a, 8'($urandom), ss, sb,
               "R1 R8 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule